// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading descriptors from memory, level by level. A request comes with the logical address, the privilege of the access, a write flag and a test-only flag. If an external transparent window already claims the address, or if paging is switched off, the address goes straight through unchanged. Otherwise the walker reads a root descriptor, then a pointer descriptor, then a page descriptor, over a simple request/acknowledge port that reads one 32-bit word at a time. It follows indirect page descriptors as far as a bounded number of steps.

At the end of each walk the block pulses a done strobe and gives either the physical address or a fault with a kind code. Write protection is collected from all three levels, and pages can be marked for supervisor use only. In test-only mode no fault is reported. The first fault after a clear records its logical address in a sticky capture register, so that software can later find which access failed first.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the walker is idle with req_ready=1, mem_req=0, done=0, fault=0 and fault_pending=0.
- R2: When window_hit=1 or pg_enable=0 at acceptance, the walker makes no memory read and reports paddr equal to req_vaddr with fault=0.
- R3: The first read is at root + 4*vaddr[31:25], where root is sup_root when req_supervisor=1 and usr_root otherwise.
- R4: A root descriptor needs bit 1 set; the next read is at (root descriptor with bits 8:0 cleared) + 4*vaddr[24:18]. A root descriptor with bit 1 clear ends the walk with fault kind 1 (invalid) after one read.
- R5: A pointer descriptor needs bit 1 set, or the walk ends with kind 1. With pg_big=0 the page read is at (pointer with bits 7:0 cleared) + 4*vaddr[17:12]; with pg_big=1 it is at (pointer with bits 6:0 cleared) + 4*vaddr[17:13].
- R6: A page descriptor of type (bits 1:0) 1 or 3 gives paddr = descriptor bits 31:12 joined with vaddr[11:0] (pg_big=0), or bits 31:13 joined with vaddr[12:0] (pg_big=1). Type 0 ends with kind 1.
- R7: A page descriptor of type 2 is indirect: the next read is at that descriptor with bits 1:0 cleared, repeated while type 2 comes back. When the fourth indirect read still returns type 2, the walk ends with kind 1.
- R8: A write whose root, pointer or page descriptor has bit 2 set ends with kind 2 (write protect); a read with the same tables translates normally.
- R9: An access with req_supervisor=0 to a page descriptor with bit 7 set ends with kind 3 (privilege); a supervisor access translates.
- R10: With req_probe=1 no fault is reported and fault_pending is untouched; an invalid descriptor gives paddr equal to req_vaddr, and protection bits are ignored.
- R11: A fault with fault_pending=0 sets fault_pending and stores the logical address in fault_vaddr; later faults leave it unchanged until fault_clr. A fault in the same cycle as fault_clr is captured.
- R12: req_ready is low while a walk is running and requests then are ignored; mem_req stays high with mem_addr stable until mem_ack.
- R13: done is a single-cycle pulse per walk, with paddr, fault and fault_kind valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_enable | input | 1 | Paging switched on |
| pg_big | input | 1 | 1 selects 8 KiB pages, 0 selects 4 KiB pages |
| sup_root | input | 32 | Root table base for supervisor accesses |
| usr_root | input | 32 | Root table base for user accesses |
| req_valid | input | 1 | New translation request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Logical address |
| req_supervisor | input | 1 | Access is privileged |
| req_write | input | 1 | Access is a write |
| req_probe | input | 1 | Test-only access, faults suppressed |
| window_hit | input | 1 | A transparent window claims the address |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| paddr | output | 32 | Physical address result |
| fault | output | 1 | Walk ended in a fault |
| fault_kind | output | 2 | 0 none, 1 invalid, 2 write protect, 3 privilege |
| fault_clr | input | 1 | Clear the captured fault |
| fault_pending | output | 1 | A fault has been captured |
| fault_vaddr | output | 32 | Logical address of the first captured fault |

## Verification
The fault capture register can be cleared and loaded by a new fault in the same clock edge. The bench holds fault_clr high for the whole of a walk that ends in an invalid root descriptor, so the clear and the fault capture meet on the edge that finishes the walk. It then expects fault_pending still set and fault_vaddr holding the new logical address rather than the earlier one.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int AW = 32;
  // decoded control and descriptor bit positions
  localparam int D_VALID_BIT = 1;
  localparam int D_WP_BIT    = 2;
  localparam int D_SUPER_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROOT, ST_PTR, ST_PAGE, ST_IND, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    FK_NONE    = 2'd0,
    FK_INVALID = 2'd1,
    FK_WPROT   = 2'd2,
    FK_PRIV    = 2'd3
  } fault_kind_e;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int AW               = 32,
  parameter int ROOT_IDX_W       = 7,
  parameter int PTR_IDX_W        = 7,
  parameter int PAGE_SHIFT_SMALL = 12
) (
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] root_base,
  input  logic [AW-1:0] desc,
  input  logic          big_page,
  output logic [AW-1:0] root_rd,
  output logic [AW-1:0] ptr_rd,
  output logic [AW-1:0] page_rd,
  output logic [AW-1:0] ind_rd,
  output logic [AW-1:0] phys
);
  localparam int DSH            = 2;  // 4-byte descriptors
  localparam int ROOT_LSB       = AW - ROOT_IDX_W;
  localparam int PTR_LSB        = ROOT_LSB - PTR_IDX_W;
  localparam int PAGE_SHIFT_BIG = PAGE_SHIFT_SMALL + 1;
  localparam int SM_IDX_W       = PTR_LSB - PAGE_SHIFT_SMALL;
  localparam int BG_IDX_W       = PTR_LSB - PAGE_SHIFT_BIG;
  localparam int PTR_ALIGN      = PTR_IDX_W + DSH;
  localparam int SM_ALIGN       = SM_IDX_W + DSH;
  localparam int BG_ALIGN       = BG_IDX_W + DSH;
  localparam logic [AW-1:0] ONES = '1;

  logic [ROOT_IDX_W-1:0] root_idx;
  logic [PTR_IDX_W-1:0]  ptr_idx;
  logic [SM_IDX_W-1:0]   sm_idx;
  logic [BG_IDX_W-1:0]   bg_idx;

  assign root_idx = vaddr[AW-1 -: ROOT_IDX_W];
  assign ptr_idx  = vaddr[ROOT_LSB-1 -: PTR_IDX_W];
  assign sm_idx   = vaddr[PTR_LSB-1 -: SM_IDX_W];
  assign bg_idx   = vaddr[PTR_LSB-1 -: BG_IDX_W];

  assign root_rd = root_base + (AW'(root_idx) << DSH);
  assign ptr_rd  = (desc & (ONES << PTR_ALIGN)) + (AW'(ptr_idx) << DSH);
  assign ind_rd  = desc & (ONES << DSH);

  always_comb begin
    if (big_page) begin
      page_rd = (desc & (ONES << BG_ALIGN)) + (AW'(bg_idx) << DSH);
      phys    = (desc & (ONES << PAGE_SHIFT_BIG)) | (vaddr & ~(ONES << PAGE_SHIFT_BIG));
    end else begin
      page_rd = (desc & (ONES << SM_ALIGN)) + (AW'(sm_idx) << DSH);
      phys    = (desc & (ONES << PAGE_SHIFT_SMALL)) | (vaddr & ~(ONES << PAGE_SHIFT_SMALL));
    end
  end
endmodule

// File: rtl/pgwalk_page_judge.sv
module pgwalk_page_judge
  import pgwalk_pkg::*;
(
  input  logic [1:0]  dtype,
  input  logic        wp_bit,
  input  logic        super_bit,
  input  logic        wp_upper,
  input  logic        is_write,
  input  logic        is_sup,
  output logic        is_indirect,
  output logic        is_bad,
  output fault_kind_e prot_kind
);
  assign is_indirect = (dtype == 2'd2);
  assign is_bad      = (dtype == 2'd0);

  always_comb begin
    if (is_write && (wp_bit || wp_upper))  prot_kind = FK_WPROT;
    else if (super_bit && !is_sup)         prot_kind = FK_PRIV;
    else                                   prot_kind = FK_NONE;
  end
endmodule

// File: rtl/pgwalk_fcap.sv
module pgwalk_fcap #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  logic [AW-1:0] ev_vaddr,
  input  logic          clr,
  output logic          pending,
  output logic [AW-1:0] vaddr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      vaddr   <= '0;
    end else begin
      if (ev) pending <= 1'b1;
      else if (clr) pending <= 1'b0;
      if (ev && (!pending || clr)) vaddr <= ev_vaddr;
    end
  end

  // R11
  fcap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pending && !clr |=> pending && $stable(vaddr));
  // R11
  fcap_first_chk: assert property (@(posedge clk) disable iff (rst)
    ev && !pending |=> pending && vaddr == $past(ev_vaddr));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int IND_LIMIT        = 4,
  parameter int ROOT_IDX_W       = 7,
  parameter int PTR_IDX_W        = 7,
  parameter int PAGE_SHIFT_SMALL = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pg_enable,
  input  logic          pg_big,
  input  logic [AW-1:0] sup_root,
  input  logic [AW-1:0] usr_root,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  input  logic          req_supervisor,
  input  logic          req_write,
  input  logic          req_probe,
  input  logic          window_hit,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] paddr,
  output logic          fault,
  output logic [1:0]    fault_kind,
  input  logic          fault_clr,
  output logic          fault_pending,
  output logic [AW-1:0] fault_vaddr
);
  localparam int CNT_W = $clog2(IND_LIMIT + 1);

  walk_st_e    st, st_n;
  logic [AW-1:0] va_q, maddr_n, fin_pa;
  logic        sup_q, wr_q, probe_q, big_q;
  logic        wp_q, wp_n, mreq_n, fin;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  fault_kind_e fin_kind, kind_q;

  logic [AW-1:0] va_sel, root_sel;
  logic        big_sel;
  logic [AW-1:0] root_rd, ptr_rd, page_rd, ind_rd, phys;
  logic        pg_indirect, pg_bad;
  fault_kind_e pg_prot;

  assign va_sel   = (st == ST_IDLE) ? req_vaddr : va_q;
  assign big_sel  = (st == ST_IDLE) ? pg_big : big_q;
  assign root_sel = req_supervisor ? sup_root : usr_root;

  pgwalk_addr #(
    .AW(AW), .ROOT_IDX_W(ROOT_IDX_W), .PTR_IDX_W(PTR_IDX_W),
    .PAGE_SHIFT_SMALL(PAGE_SHIFT_SMALL)
  ) u_addr (
    .vaddr(va_sel), .root_base(root_sel), .desc(mem_rdata), .big_page(big_sel),
    .root_rd(root_rd), .ptr_rd(ptr_rd), .page_rd(page_rd), .ind_rd(ind_rd),
    .phys(phys)
  );

  pgwalk_page_judge u_judge (
    .dtype(mem_rdata[1:0]), .wp_bit(mem_rdata[D_WP_BIT]),
    .super_bit(mem_rdata[D_SUPER_BIT]), .wp_upper(wp_q),
    .is_write(wr_q), .is_sup(sup_q),
    .is_indirect(pg_indirect), .is_bad(pg_bad), .prot_kind(pg_prot)
  );

  always_comb begin
    st_n     = st;
    maddr_n  = mem_addr;
    mreq_n   = mem_req;
    wp_n     = wp_q;
    cnt_n    = cnt_q;
    fin      = 1'b0;
    fin_pa   = va_q;
    fin_kind = FK_NONE;
    case (st)
      ST_IDLE: if (req_valid) begin
        if (window_hit || !pg_enable) begin
          fin    = 1'b1;
          fin_pa = req_vaddr;
        end else begin
          st_n    = ST_ROOT;
          mreq_n  = 1'b1;
          maddr_n = root_rd;
          wp_n    = 1'b0;
        end
      end
      ST_ROOT: if (mem_ack) begin
        wp_n = mem_rdata[D_WP_BIT];
        if (!mem_rdata[D_VALID_BIT]) begin
          fin      = 1'b1;
          fin_kind = probe_q ? FK_NONE : FK_INVALID;
        end else begin
          st_n    = ST_PTR;
          maddr_n = ptr_rd;
        end
      end
      ST_PTR: if (mem_ack) begin
        wp_n = wp_q | mem_rdata[D_WP_BIT];
        if (wp_n && wr_q && !probe_q) begin
          fin      = 1'b1;
          fin_kind = FK_WPROT;
        end else if (!mem_rdata[D_VALID_BIT]) begin
          fin      = 1'b1;
          fin_kind = probe_q ? FK_NONE : FK_INVALID;
        end else begin
          st_n    = ST_PAGE;
          maddr_n = page_rd;
        end
      end
      ST_PAGE, ST_IND: if (mem_ack) begin
        if (pg_indirect) begin
          if (st == ST_IND && cnt_q == CNT_W'(IND_LIMIT)) begin
            fin      = 1'b1;
            fin_kind = probe_q ? FK_NONE : FK_INVALID;
          end else begin
            st_n    = ST_IND;
            maddr_n = ind_rd;
            cnt_n   = (st == ST_PAGE) ? CNT_W'(1) : cnt_q + CNT_W'(1);
          end
        end else if (probe_q) begin
          fin    = 1'b1;
          fin_pa = pg_bad ? va_q : phys;
        end else if (pg_prot != FK_NONE) begin
          fin      = 1'b1;
          fin_kind = pg_prot;
        end else if (pg_bad) begin
          fin      = 1'b1;
          fin_kind = FK_INVALID;
        end else begin
          fin    = 1'b1;
          fin_pa = phys;
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
    if (fin) begin
      st_n   = ST_DONE;
      mreq_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      wp_q     <= 1'b0;
      cnt_q    <= '0;
      va_q     <= '0;
      sup_q    <= 1'b0;
      wr_q     <= 1'b0;
      probe_q  <= 1'b0;
      big_q    <= 1'b0;
      done     <= 1'b0;
      paddr    <= '0;
      fault    <= 1'b0;
      kind_q   <= FK_NONE;
    end else begin
      st       <= st_n;
      mem_req  <= mreq_n;
      mem_addr <= maddr_n;
      wp_q     <= wp_n;
      cnt_q    <= cnt_n;
      done     <= fin;
      if (st == ST_IDLE && req_valid) begin
        va_q    <= req_vaddr;
        sup_q   <= req_supervisor;
        wr_q    <= req_write;
        probe_q <= req_probe;
        big_q   <= pg_big;
      end
      if (fin) begin
        paddr  <= fin_pa;
        fault  <= (fin_kind != FK_NONE);
        kind_q <= fin_kind;
      end
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign fault_kind = kind_q;

  pgwalk_fcap #(.AW(AW)) u_fcap (
    .clk(clk), .rst(rst), .ev(fin && fin_kind != FK_NONE), .ev_vaddr(va_q),
    .clr(fault_clr), .pending(fault_pending), .vaddr(fault_vaddr)
  );

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  probe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done && probe_q |-> !fault);
  // R13
  fault_kind_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (fault == (fault_kind != 2'd0)));
endmodule

// File: tb/pgwalk_top_tb.sv
`timescale 1ns/1ps
module pgwalk_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg_enable = 1'b0, pg_big = 1'b0;
  logic [31:0] sup_root = '0, usr_root = '0;
  logic req_valid = 1'b0, req_supervisor = 1'b0, req_write = 1'b0;
  logic req_probe = 1'b0, window_hit = 1'b0, fault_clr = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, mem_req, done, fault, fault_pending;
  logic [31:0] mem_addr, paddr, fault_vaddr;
  logic [1:0] fault_kind;
  logic mem_ack;
  logic [31:0] mem_rdata;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] addr_log [$];
  logic [31:0] r_pa;
  logic r_fault;
  logic [1:0] r_kind;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rst(rst), .pg_enable(pg_enable), .pg_big(pg_big),
    .sup_root(sup_root), .usr_root(usr_root), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_supervisor(req_supervisor),
    .req_write(req_write), .req_probe(req_probe), .window_hit(window_hit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .paddr(paddr), .fault(fault), .fault_kind(fault_kind),
    .fault_clr(fault_clr), .fault_pending(fault_pending), .fault_vaddr(fault_vaddr)
  );

  function automatic logic [31:0] rdmem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= rdmem(mem_addr);
        addr_log.push_back(mem_addr);
      end
    end
  end

  function automatic logic [31:0] a_root(input logic [31:0] root, va);
    return root + ((va >> 25) << 2);
  endfunction
  function automatic logic [31:0] a_ptr(input logic [31:0] rd, va);
    return (rd & ~32'h1FF) + (((va >> 18) & 32'h7F) << 2);
  endfunction
  function automatic logic [31:0] a_page(input logic [31:0] pd, va, input logic big);
    return big ? (pd & ~32'h7F) + (((va >> 13) & 32'h1F) << 2)
               : (pd & ~32'hFF) + (((va >> 12) & 32'h3F) << 2);
  endfunction
  function automatic logic [31:0] x_phys(input logic [31:0] d, va, input logic big);
    return big ? ((d & ~32'h1FFF) | (va & 32'h1FFF)) : ((d & ~32'hFFF) | (va & 32'hFFF));
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic tables(input logic [31:0] root, va, rd, pd, pgd, input logic big);
    mem.delete();
    mem[a_root(root, va)] = rd;
    mem[a_ptr(rd, va)] = pd;
    mem[a_page(pd, va, big)] = pgd;
  endtask

  task automatic walk(input logic [31:0] va, input logic sup, wr, pr, hit, input bit poke);
    int g;
    addr_log.delete();
    @(negedge clk);
    req_vaddr = va; req_supervisor = sup; req_write = wr; req_probe = pr;
    window_hit = hit; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      chk("R12 req_ready low during walk", {31'b0, req_ready}, 32'd0);
      req_valid = 1'b1; req_vaddr = ~va;
      @(negedge clk);
      req_valid = 1'b0;
    end
    g = 0;
    while (!done && g < 300) begin
      @(negedge clk);
      g++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R13 walk never finished: actual done=0 expected done=1");
    end
    r_pa = paddr; r_fault = fault; r_kind = fault_kind;
  endtask

  task automatic pulse_clr();
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 fault", {31'b0, fault}, 32'd0);
    chk("R1 fault_pending", {31'b0, fault_pending}, 32'd0);
  endtask

  task automatic t_bypass();
    pg_enable = 1'b0;
    walk(32'h1234_5678, 1, 0, 0, 0, 0);
    chk("R2 disabled paddr", r_pa, 32'h1234_5678);
    chk("R2 disabled reads", addr_log.size(), 0);
    pg_enable = 1'b1;
    walk(32'hCAFE_0123, 1, 1, 0, 1, 0);
    chk("R2 window paddr", r_pa, 32'hCAFE_0123);
    chk("R2 window fault", {31'b0, r_fault}, 0);
    chk("R2 window reads", addr_log.size(), 0);
  endtask

  task automatic t_sup_small();
    logic [31:0] va = 32'h8A5C_3ABC;
    pg_enable = 1; pg_big = 0; sup_root = 32'h0001_0000; usr_root = 32'h0070_0000;
    tables(sup_root, va, 32'h0002_01F2, 32'h0003_00F6, 32'h0ABC_D0F5, 0);
    walk(va, 1, 0, 0, 0, 0);
    chk("R3 supervisor root read", addr_log[0], a_root(sup_root, va));
    chk("R4 pointer read", addr_log[1], a_ptr(32'h0002_01F2, va));
    chk("R5 4K page read", addr_log[2], a_page(32'h0003_00F6, va, 0));
    chk("R6 4K paddr", r_pa, x_phys(32'h0ABC_D0F5, va, 0));
    chk("R6 no fault", {31'b0, r_fault}, 0);
    chk("R6 read count", addr_log.size(), 3);
    @(negedge clk);
    chk("R13 done one cycle", {31'b0, done}, 0);
  endtask

  task automatic t_user_big();
    logic [31:0] va = 32'h1357_9BDF;
    pg_big = 1; usr_root = 32'h0004_0000;
    tables(usr_root, va, 32'h0005_0002, 32'h0006_00C2, 32'h2468_0003, 1);
    walk(va, 0, 0, 0, 0, 0);
    chk("R3 user root read", addr_log[0], a_root(usr_root, va));
    chk("R5 8K page read", addr_log[2], a_page(32'h0006_00C2, va, 1));
    chk("R6 8K paddr", r_pa, x_phys(32'h2468_0003, va, 1));
    pg_big = 0;
  endtask

  task automatic t_indirect();
    logic [31:0] va = 32'h4444_5555;
    tables(sup_root, va, 32'h0002_0002, 32'h0003_0002, 32'h0007_0102, 0);
    mem[32'h0007_0100] = 32'h0008_0006;
    mem[32'h0008_0004] = 32'h0ABC_0001;
    walk(va, 1, 0, 0, 0, 0);
    chk("R7 reads", addr_log.size(), 5);
    chk("R7 first indirect", addr_log[3], 32'h0007_0100);
    chk("R7 second indirect", addr_log[4], 32'h0008_0004);
    chk("R7 paddr", r_pa, x_phys(32'h0ABC_0001, va, 0));
    tables(sup_root, va, 32'h0002_0002, 32'h0003_0002, 32'h0009_0002, 0);
    mem[32'h0009_0000] = 32'h0009_0002;
    walk(va, 1, 0, 0, 0, 0);
    chk("R7 loop kind", {30'b0, r_kind}, 1);
    chk("R7 loop reads", addr_log.size(), 7);
  endtask

  task automatic t_invalid();
    logic [31:0] va = 32'h0F0F_1234;
    pulse_clr();
    tables(sup_root, va, 32'h0002_0001, 32'h0003_0002, 32'h0000_1001, 0);
    walk(va, 1, 0, 0, 0, 0);
    chk("R4 root invalid kind", {30'b0, r_kind}, 1);
    chk("R4 root invalid reads", addr_log.size(), 1);
    chk("R11 pending", {31'b0, fault_pending}, 1);
    chk("R11 captured vaddr", fault_vaddr, va);
    tables(sup_root, va, 32'h0002_0002, 32'h0003_0000, 32'h0000_1001, 0);
    walk(va, 1, 0, 0, 0, 0);
    chk("R5 pointer invalid kind", {30'b0, r_kind}, 1);
    chk("R5 pointer invalid reads", addr_log.size(), 2);
    tables(sup_root, va, 32'h0002_0002, 32'h0003_0002, 32'h0ABC_D000, 0);
    walk(va, 1, 0, 0, 0, 0);
    chk("R6 page type0 kind", {30'b0, r_kind}, 1);
    chk("R6 page type0 fault", {31'b0, r_fault}, 1);
  endtask

  task automatic t_protect();
    logic [31:0] va = 32'h2222_3333;
    tables(sup_root, va, 32'h0002_0006, 32'h0003_0002, 32'h0ABC_D001, 0);
    walk(va, 1, 1, 0, 0, 0);
    chk("R8 root WP kind", {30'b0, r_kind}, 2);
    chk("R8 root WP reads", addr_log.size(), 2);
    walk(va, 1, 0, 0, 0, 0);
    chk("R8 read unaffected", r_pa, x_phys(32'h0ABC_D001, va, 0));
    tables(sup_root, va, 32'h0002_0002, 32'h0003_0002, 32'h0ABC_D005, 0);
    walk(va, 1, 1, 0, 0, 0);
    chk("R8 page WP kind", {30'b0, r_kind}, 2);
    tables(usr_root, va, 32'h0002_0002, 32'h0003_0002, 32'h0ABC_D081, 0);
    walk(va, 0, 0, 0, 0, 0);
    chk("R9 user on supervisor page", {30'b0, r_kind}, 3);
    tables(sup_root, va, 32'h0002_0002, 32'h0003_0002, 32'h0ABC_D081, 0);
    walk(va, 1, 0, 0, 0, 0);
    chk("R9 supervisor allowed", r_pa, x_phys(32'h0ABC_D081, va, 0));
  endtask

  task automatic t_probe();
    logic [31:0] va = 32'h5A5A_0FF0;
    pulse_clr();
    tables(sup_root, va, 32'h0002_0000, 32'h0003_0002, 32'h0ABC_D001, 0);
    walk(va, 1, 0, 1, 0, 0);
    chk("R10 probe invalid no fault", {31'b0, r_fault}, 0);
    chk("R10 probe paddr passthrough", r_pa, va);
    chk("R10 pending untouched", {31'b0, fault_pending}, 0);
    tables(usr_root, va, 32'h0002_0002, 32'h0003_0002, 32'h0ABC_D085, 0);
    walk(va, 0, 1, 1, 0, 0);
    chk("R10 probe ignores protection", r_pa, x_phys(32'h0ABC_D085, va, 0));
    chk("R10 probe protection no fault", {31'b0, r_fault}, 0);
  endtask

  task automatic t_first_fault();
    logic [31:0] va1 = 32'h1111_0000, va2 = 32'h7777_0000, va3 = 32'h3C3C_0000;
    pulse_clr();
    tables(sup_root, va1, 32'h0002_0000, 32'h0, 32'h0, 0);
    walk(va1, 1, 0, 0, 0, 0);
    tables(sup_root, va2, 32'h0002_0000, 32'h0, 32'h0, 0);
    walk(va2, 1, 0, 0, 0, 0);
    chk("R11 first fault kept", fault_vaddr, va1);
    pulse_clr();
    chk("R11 cleared", {31'b0, fault_pending}, 0);
    tables(sup_root, va3, 32'h0002_0000, 32'h0, 32'h0, 0);
    @(negedge clk); fault_clr = 1'b1;
    walk(va3, 1, 0, 0, 0, 0);
    fault_clr = 1'b0;
    chk("R11 capture wins over clear", {31'b0, fault_pending}, 1);
    chk("R11 capture address with clear", fault_vaddr, va3);
  endtask

  task automatic t_busy();
    logic [31:0] va = 32'h6060_6060;
    tables(sup_root, va, 32'h0002_0002, 32'h0003_0002, 32'h0DEF_0003, 0);
    walk(va, 1, 0, 0, 0, 1);
    chk("R12 busy request ignored paddr", r_pa, x_phys(32'h0DEF_0003, va, 0));
    chk("R12 busy request reads", addr_log.size(), 3);
    repeat (3) @(negedge clk);
    chk("R12 no walk started", {31'b0, req_ready}, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_sup_small();
    t_user_big();
    t_indirect();
    t_invalid();
    t_protect();
    t_probe();
    t_first_fault();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule